// File: doc/BRIEF.md
# Dual-Channel Lissajous Waveform Generator

This block drives a pair of 8-bit digital-to-analog converters that feed the horizontal and vertical inputs of an oscilloscope in X-Y mode. One shared sample index runs through a 256-point frame. Each enabled sample reads one stored sine period at two addresses. The vertical channel steps through the table 1, 2 or 3 times per frame, which sets an integer frequency ratio against the horizontal channel. The horizontal channel can be advanced by a quarter period. Because both channels are locked to the same index, the pair traces a closed figure that repeats every 256 samples.

The sine table is built from a formula when the design is elaborated. It is read through registered ports, so each result appears one cycle after its enable, together with a one-cycle valid strobe. Both channels update in the same cycle. The ratio and phase controls are sampled only at the first sample of each frame, so a figure is never drawn half in one shape and half in another. The converters take every sample, so the output side has no back-pressure. Pacing is set by how often the sample enable is driven high.

Top module: `lissajous_gen`

## Requirements
- R1: A synchronous active-high reset sets both `x_out` and `y_out` to mid-scale (128), clears `out_valid` and returns the sample index to 0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `sample_en` was high, and low otherwise.
- R3: The stored table entry i (0..255) equals round(127.5 + 127.5·sin(2πi/256)), so entry 0 is 128, entry 64 is 255 and entry 192 is 0.
- R4: For the sample at index k, `x_out` is table entry (k + P) mod 256, where P = 64 when `phase_sel` is 1 and P = 0 when it is 0.
- R5: For the sample at index k, `y_out` is table entry (k·M) mod 256, where M is 1, 2 or 3 for `ratio_sel` values 1, 2 and 3. A value of 0 is treated as 1.
- R6: The sample index advances by one on each enabled sample only and wraps from 255 to 0.
- R7: `ratio_sel` and `phase_sel` are captured at the index-0 sample and apply to all 256 samples of that frame. Changes made mid-frame have no effect until the next index-0 sample.
- R8: Over one full frame, `y_out` crosses upward through mid-scale (previous value below 128, current value at least 128, taken cyclically) exactly M times, and `x_out` exactly once.
- R9: With M = 1 and the quarter offset selected, `x_out` at index k equals `y_out` at index (k + 64) mod 256.
- R10: While `sample_en` is low, `x_out`, `y_out` and the sample index hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Take one sample and advance the index |
| ratio_sel | input | 2 | Vertical frequency multiple (0 or 1 gives 1, 2, 3) |
| phase_sel | input | 1 | 1 advances the horizontal channel by a quarter period |
| x_out | output | 8 | Horizontal sample code, unsigned |
| y_out | output | 8 | Vertical sample code, unsigned |
| out_valid | output | 1 | High for the cycle in which new codes are presented |

## Verification
A corrupted sample index would show at once as codes that do not match the table position expected from the number of enables since reset. After a full frame it would also show as a wrong crossing count or as frames that no longer line up. Settings latched at the wrong moment would give a frame whose first samples follow one ratio and whose later samples follow another. This can be seen within the frame in which the controls change. A wrong table entry shows on the first sample that addresses it, for example at the known peaks and the midpoint.

// File: rtl/lsj_pkg.sv
package lsj_pkg;

  typedef struct packed {
    logic [1:0] mult;
    logic       quad;
  } frame_cfg_t;

  // Sine of an angle in [0, pi/2] by odd power series.
  function automatic real quarter_sin(real a);
    real term;
    real sum;
    term = a;
    sum  = a;
    for (int k = 1; k < 9; k++) begin
      term = -term * a * a / (real'(2 * k) * real'(2 * k + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // Unsigned code of one period of a sine over 2**aw points, full swing on dw bits.
  function automatic int sine_code(int i, int aw, int dw);
    int  n;
    int  q;
    int  ph;
    int  r;
    int  quad;
    int  code;
    int  top;
    real step;
    real half;
    real a;
    real s;
    n    = 1 << aw;
    q    = n / 4;
    ph   = i % n;
    r    = ph % q;
    quad = ph / q;
    top  = (1 << dw) - 1;
    step = 2.0 * 3.14159265358979323846 / real'(n);
    half = real'(top) / 2.0;
    if (quad == 0 || quad == 2) a = real'(r) * step;
    else                        a = real'(q - r) * step;
    s = quarter_sin(a);
    if (quad >= 2) s = -s;
    code = $rtoi(half + half * s + 0.5);
    if (code < 0)   code = 0;
    if (code > top) code = top;
    return code;
  endfunction

endpackage

// File: rtl/lsj_frame_ctrl.sv
module lsj_frame_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sample_en,
  input  logic [1:0]             ratio_sel,
  input  logic                   phase_sel,
  output logic [ADDR_W-1:0]      idx,
  output lsj_pkg::frame_cfg_t    cfg_use,
  output lsj_pkg::frame_cfg_t    cfg_held
);
  import lsj_pkg::*;

  logic [ADDR_W-1:0] idx_q;
  frame_cfg_t        held_q;
  frame_cfg_t        live;
  logic              at_start;

  assign at_start  = (idx_q == '0);
  assign live.mult = (ratio_sel == 2'd0) ? 2'd1 : ratio_sel;
  assign live.quad = phase_sel;
  assign cfg_use   = at_start ? live : held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      held_q.mult <= 2'd1;
      held_q.quad <= 1'b0;
    end else if (sample_en) begin
      idx_q <= idx_q + 1'b1;
      if (at_start) held_q <= live;
    end
  end

  assign idx      = idx_q;
  assign cfg_held = held_q;
endmodule

// File: rtl/lsj_addr_gen.sv
module lsj_addr_gen #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    idx,
  input  lsj_pkg::frame_cfg_t  cfg,
  output logic [ADDR_W-1:0]    addr_x,
  output logic [ADDR_W-1:0]    addr_y
);
  localparam int PW = ADDR_W + 2;
  localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1 << (ADDR_W - 2));

  logic [PW-1:0] prod;

  assign prod   = PW'(idx) * PW'(cfg.mult);
  assign addr_y = prod[ADDR_W-1:0];
  assign addr_x = idx + (cfg.quad ? QUARTER : '0);
endmodule

// File: rtl/lsj_sine_rom.sv
module lsj_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PORTS  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
  output logic [PORTS-1:0][DATA_W-1:0]  data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

  logic [DATA_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign tbl[i] = DATA_W'(lsj_pkg::sine_code(i, ADDR_W, DATA_W));
  end

  logic [PORTS-1:0][DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PORTS; p++) data_q[p] <= MID;
    end else if (rd_en) begin
      for (int p = 0; p < PORTS; p++) data_q[p] <= tbl[addr[p]];
    end
  end

  assign data = data_q;
endmodule

// File: rtl/lissajous_gen.sv
module lissajous_gen #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic [1:0]        ratio_sel,
  input  logic              phase_sel,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] y_out,
  output logic              out_valid
);
  import lsj_pkg::*;

  logic [ADDR_W-1:0]           frame_idx;
  frame_cfg_t                  cfg_use;
  frame_cfg_t                  cfg_held;
  logic [1:0]                  held_mult;
  logic                        held_quad;
  logic [ADDR_W-1:0]           addr_x;
  logic [ADDR_W-1:0]           addr_y;
  logic [1:0][ADDR_W-1:0]      rd_addr;
  logic [1:0][DATA_W-1:0]      rd_data;
  logic                        valid_q;

  lsj_frame_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .ratio_sel (ratio_sel),
    .phase_sel (phase_sel),
    .idx       (frame_idx),
    .cfg_use   (cfg_use),
    .cfg_held  (cfg_held)
  );

  lsj_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .idx    (frame_idx),
    .cfg    (cfg_use),
    .addr_x (addr_x),
    .addr_y (addr_y)
  );

  assign rd_addr[0] = addr_x;
  assign rd_addr[1] = addr_y;

  lsj_sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(2)) u_rom (
    .clk   (clk),
    .rst   (rst),
    .rd_en (sample_en),
    .addr  (rd_addr),
    .data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= sample_en;
  end

  assign held_mult = cfg_held.mult;
  assign held_quad = cfg_held.quad;
  assign x_out     = rd_data[0];
  assign y_out     = rd_data[1];
  assign out_valid = valid_q;
endmodule

// File: rtl/lissajous_gen_chk.sv
module lissajous_gen_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_en,
  input logic [DATA_W-1:0] x_out,
  input logic [DATA_W-1:0] y_out,
  input logic              out_valid,
  input logic [ADDR_W-1:0] idx,
  input logic [1:0]        held_mult,
  input logic              held_quad
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

  p_reset_mid_r1: assert property (@(posedge clk)
    rst |=> (x_out == MID && y_out == MID && !out_valid && idx == '0));

  p_valid_after_en_r2: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> out_valid);

  p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> !out_valid);

  p_index_step_r6: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> idx == ADDR_W'($past(idx) + 1'b1));

  p_index_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(idx));

  p_codes_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(x_out) && $stable(y_out)));

  p_cfg_frame_r7: assert property (@(posedge clk) disable iff (rst)
    !(sample_en && idx == '0) |=> ($stable(held_mult) && $stable(held_quad)));

  p_mult_range_r5: assert property (@(posedge clk) disable iff (rst)
    held_mult != 2'd0);
endmodule

bind lissajous_gen lissajous_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample_en (sample_en),
  .x_out     (x_out),
  .y_out     (y_out),
  .out_valid (out_valid),
  .idx       (frame_idx),
  .held_mult (held_mult),
  .held_quad (held_quad)
);

// File: tb/lissajous_gen_test.sv
`timescale 1ns/1ps
module lissajous_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b0;
  logic [1:0] ratio_sel = 2'd1;
  logic       phase_sel = 1'b0;
  logic [7:0] x_out;
  logic [7:0] y_out;
  logic       out_valid;

  always #2.5 clk = ~clk;

  lissajous_gen uut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .ratio_sel(ratio_sel),
    .phase_sel(phase_sel), .x_out(x_out), .y_out(y_out), .out_valid(out_valid)
  );

  int errs = 0;
  int checks = 0;
  int xs [256];
  int ys [256];
  int vbad;

  // columns: ratio_sel, phase_sel, expected x upward crossings, expected y upward crossings
  localparam int VEC [6][4] = '{
    '{1, 0, 1, 1}, '{2, 0, 1, 2}, '{3, 0, 1, 3},
    '{3, 1, 1, 3}, '{0, 1, 1, 1}, '{1, 1, 1, 1}
  };

  function automatic int sref(int i);
    return $rtoi(127.5 + 127.5 * $sin(2.0 * 3.141592653589793 * real'(i % 256) / 256.0) + 0.5);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic take_sample();
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int crossings(ref int arr [256]);
    int c = 0;
    for (int k = 0; k < 256; k++)
      if (arr[(k + 255) % 256] < 128 && arr[k] >= 128) c++;
    return c;
  endfunction

  task automatic run_frame(int r, int p);
    vbad = 0;
    ratio_sel = 2'(r);
    phase_sel = p[0];
    for (int k = 0; k < 256; k++) begin
      take_sample();
      xs[k] = int'(x_out);
      ys[k] = int'(y_out);
      if (!out_valid) vbad++;
    end
  endtask

  task automatic verify_frame(int r, int p);
    int m;
    int off;
    int nx = 0;
    int ny = 0;
    int fxa = 0, fxe = 0, fya = 0, fye = 0;
    m   = (r == 0) ? 1 : r;
    off = p ? 64 : 0;
    for (int k = 0; k < 256; k++) begin
      if (xs[k] != sref(k + off)) begin
        if (nx == 0) begin fxa = xs[k]; fxe = sref(k + off); end
        nx++;
      end
      if (ys[k] != sref((k * m) % 256)) begin
        if (ny == 0) begin fya = ys[k]; fye = sref((k * m) % 256); end
        ny++;
      end
    end
    check(nx == 0, "R4", "x code over frame (first mismatch)", fxa, fxe);
    check(ny == 0, "R5", "y code over frame (first mismatch)", fya, fye);
    check(vbad == 0, "R2", "samples without valid", vbad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=0 expected=1");
    errs++;
    checks++;
    finish_up();
  end

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    check(x_out == 8'd128, "R1", "x after reset", x_out, 128);
    check(y_out == 8'd128, "R1", "y after reset", y_out, 128);
    check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);

    // R3: known table points through the first sample
    ratio_sel = 2'd1;
    phase_sel = 1'b1;
    take_sample();
    check(x_out == 8'd255, "R3", "x at entry 64", x_out, 255);
    check(y_out == 8'd128, "R3", "y at entry 0", y_out, 128);
    check(out_valid == 1'b1, "R2", "valid after enable", out_valid, 1);

    // R10: idle cycles hold everything
    repeat (5) @(negedge clk);
    check(x_out == 8'd255, "R10", "x held while idle", x_out, 255);
    check(y_out == 8'd128, "R10", "y held while idle", y_out, 128);
    check(out_valid == 1'b0, "R2", "valid low while idle", out_valid, 0);
    take_sample();
    check(x_out == 8'(sref(65)), "R10", "index resumes after idle", x_out, sref(65));

    // R1: reset in mid-frame returns to index 0
    do_reset();
    check(x_out == 8'd128 && y_out == 8'd128, "R1", "mid-frame reset x", x_out, 128);
    ratio_sel = 2'd3;
    phase_sel = 1'b1;
    take_sample();
    check(x_out == 8'd255, "R1", "first sample after reset uses index 0", x_out, 255);
    do_reset();

    // Table walk: one full frame per vector
    for (int v = 0; v < 6; v++) begin
      run_frame(VEC[v][0], VEC[v][1]);
      verify_frame(VEC[v][0], VEC[v][1]);
      check(crossings(xs) == VEC[v][2], "R8", "x upward crossings", crossings(xs), VEC[v][2]);
      check(crossings(ys) == VEC[v][3], "R8", "y upward crossings", crossings(ys), VEC[v][3]);
      if (VEC[v][0] == 1 && VEC[v][1] == 1) begin
        int bad = 0;
        for (int k = 0; k < 256; k++)
          if (xs[k] != ys[(k + 64) % 256]) bad++;
        check(bad == 0, "R9", "x(k) vs y(k+64) mismatches", bad, 0);
      end
    end

    // R7: mid-frame change is ignored until the next frame
    vbad = 0;
    ratio_sel = 2'd2;
    phase_sel = 1'b0;
    for (int k = 0; k < 256; k++) begin
      if (k == 10) begin
        ratio_sel = 2'd3;
        phase_sel = 1'b1;
      end
      take_sample();
      xs[k] = int'(x_out);
      ys[k] = int'(y_out);
      if (!out_valid) vbad++;
    end
    verify_frame(2, 0);
    check(crossings(ys) == 2, "R7", "y crossings keep frame ratio", crossings(ys), 2);

    // R6: after 256 samples the index wrapped to 0; new settings now apply
    for (int k = 0; k < 4; k++) begin
      take_sample();
      check(x_out == 8'(sref(k + 64)), "R6", "x after wrap with new phase", x_out, sref(k + 64));
      check(y_out == 8'(sref((3 * k) % 256)), "R7", "y after wrap with new ratio", y_out, sref((3 * k) % 256));
    end

    finish_up();
  end
endmodule